// File: doc/BRIEF.md
# Host Register Port with Start-Gated Reset Chain

This block is the configuration port between a call-setup processor and the switch controller. The processor reaches it through an 8-bit bidirectional bus, plus a select line, a read/write line and a strobe. With select low, a transfer targets the command/status side. With select high, it targets a small file of data registers. Write cycles are latched on the rising edge of the strobe and handed to the system clock domain. Read cycles work as asynchronous output enables: the port drives the bus while the strobe is held low.

The data registers sit behind an index that steps forward by itself. A command write of any value other than the start opcode loads the index. Each data-register access, read or write, moves the index on by one, wrapping at the end of the file. A command write of the start opcode marks the controller as started. The reset-chain output is high while reset is active and stays high after reset until that start command has been applied. It is meant to feed the reset input of a following controller. The register contents are also presented as a flat vector for the rest of the controller.

Each transfer crosses the clock domains as a toggle request with a two-flop synchronizer. The host must wait for the pending flag to clear before it issues another transfer that has a side effect. Status reads have no side effect and may be issued at any time. No valid/ready stream exists here, and there is no back-pressure beyond that pending flag.

Top module: `hrb_host_port`

## Requirements
- R1: After reset, the reset-chain output is 1, a status read returns 0x00, every data register holds 0x00 and the index is 0.
- R2: The block drives the bus only while the read/write line is 1 and the strobe is 0. Write data driven by the host reaches the registers unaltered.
- R3: A read with select 0 returns a status byte. Bit 0 is the started flag, bit 1 is the pending flag, and bits 7..2 read 0. A status read changes no state.
- R4: A write is captured on the rising strobe edge and takes effect by the third rising system-clock edge after it, exactly once.
- R5: The pending flag reads 1 from the capturing strobe edge until the system clock domain has applied the transfer, and 0 afterwards.
- R6: A command write of 0x01 sets the started flag and drives the reset-chain output to 0. The flag stays set until reset, and later command writes do not clear it.
- R7: A command write of any value other than 0x01 loads the index with the value modulo the register count (its low bits) and changes no data register. A start write leaves the index unchanged.
- R8: A data write stores the byte into the register selected by the index, then advances the index by one modulo the register count.
- R9: A data read returns the register selected by the index. The rising strobe edge that ends the read advances the index by one modulo the register count.
- R10: Asserting reset at any moment immediately drives the reset-chain output to 1 and clears the started flag, the registers and the index.
- R11: Data register k appears on the configuration output at bits 8k+7 down to 8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| host_bus | inout | 8 | Bidirectional host data bus |
| host_sel | input | 1 | 1 selects the data registers, 0 selects command/status |
| host_rnw | input | 1 | 1 for read, 0 for write |
| host_strobe | input | 1 | Transfer strobe: writes latch on its rise, reads drive while it is low |
| chain_rst_out | output | 1 | Reset-chain output, high until start is applied |
| cfg_regs | output | NREG*8 | Flat view of the data registers |

## Verification
The assertions rely on the host never raising the strobe for a data transfer or a command write while the pending flag is set. Under that condition, each request toggle reaches the clock domain as a single isolated execute pulse, and the captured transfer stays stable until it is consumed. The bench waits six system clocks after every capturing strobe edge, which is longer than the synchronizer path. The only transfers it overlaps with a pending request are status reads, because they capture nothing.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  localparam logic [7:0] START_OP    = 8'h01;
  localparam int         STAT_START  = 0;
  localparam int         STAT_PEND   = 1;

  typedef struct packed {
    logic       rnw;
    logic       sel;
    logic [7:0] data;
  } hrb_xfer_t;
endpackage

// File: rtl/hrb_strobe_capture.sv
module hrb_strobe_capture
  import hrb_pkg::*;
(
  input  logic      rst,
  input  logic      host_strobe,
  input  logic      host_rnw,
  input  logic      host_sel,
  input  logic [7:0] host_din,
  output hrb_xfer_t xfer_hold,
  output logic      req_tgl
);
  // Status reads carry no side effect and are not captured, so the
  // host may poll status while an earlier transfer is still pending.
  logic capture_en;
  assign capture_en = !(host_rnw && !host_sel);

  always_ff @(posedge host_strobe or posedge rst) begin
    if (rst) begin
      xfer_hold <= '0;
      req_tgl   <= 1'b0;
    end else if (capture_en) begin
      xfer_hold.rnw  <= host_rnw;
      xfer_hold.sel  <= host_sel;
      xfer_hold.data <= host_din;
      req_tgl        <= ~req_tgl;
    end
  end
endmodule

// File: rtl/hrb_sync.sv
module hrb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge rst) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hrb_exec.sv
module hrb_exec
  import hrb_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_sync,
  input  hrb_xfer_t              xfer,
  output logic                   ack_tgl,
  output logic                   started,
  output logic [IW-1:0]          idx,
  output logic [NREG-1:0][7:0]   regs
);
  logic fire;
  assign fire = req_sync ^ ack_tgl;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ack_tgl <= 1'b0;
      started <= 1'b0;
      idx     <= '0;
      regs    <= '0;
    end else if (fire) begin
      ack_tgl <= req_sync;
      if (!xfer.rnw) begin
        if (xfer.sel) begin
          regs[idx] <= xfer.data;
          idx       <= idx + IW'(1);
        end else if (xfer.data == START_OP) begin
          started <= 1'b1;
        end else begin
          idx <= xfer.data[IW-1:0];
        end
      end else if (xfer.sel) begin
        idx <= idx + IW'(1);
      end
    end
  end

  // R6: the started flag never falls outside reset
  a_r6_start_sticky: assert property (@(posedge clk) disable iff (rst)
    started |=> started);

  // R4: a request executes once; the next cycle is quiet
  a_r4_single_fire: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  // R8: registers change only on an executing cycle
  a_r8_regs_quiet: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(regs));

  // R9: every data-side access steps the index
  a_r9_idx_step: assert property (@(posedge clk) disable iff (rst)
    (fire && xfer.sel) |=> (idx == $past(idx) + IW'(1)));

  // R7: non-start command writes load the index from the low bits
  a_r7_idx_load: assert property (@(posedge clk) disable iff (rst)
    (fire && !xfer.sel && !xfer.rnw && xfer.data != START_OP)
      |=> (idx == $past(xfer.data[IW-1:0])));
endmodule

// File: rtl/hrb_host_port.sv
module hrb_host_port
  import hrb_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int SYNC_LEN  = 2,
  localparam int IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  inout  wire  [7:0]        host_bus,
  input  logic              host_sel,
  input  logic              host_rnw,
  input  logic              host_strobe,
  output logic              chain_rst_out,
  output logic [NREG*8-1:0] cfg_regs
);
  hrb_xfer_t            xfer_hold;
  logic                 req_tgl;
  logic                 req_sync;
  logic                 ack_tgl;
  logic                 started;
  logic [IW-1:0]        idx;
  logic [NREG-1:0][7:0] regs;
  logic [7:0]           status;
  logic [7:0]           rd_val;
  logic                 rd_drive;

  hrb_strobe_capture u_cap (
    .rst         (rst),
    .host_strobe (host_strobe),
    .host_rnw    (host_rnw),
    .host_sel    (host_sel),
    .host_din    (host_bus),
    .xfer_hold   (xfer_hold),
    .req_tgl     (req_tgl)
  );

  hrb_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_tgl),
    .q   (req_sync)
  );

  hrb_exec #(.NREG(NREG)) u_exec (
    .clk      (clk),
    .rst      (rst),
    .req_sync (req_sync),
    .xfer     (xfer_hold),
    .ack_tgl  (ack_tgl),
    .started  (started),
    .idx      (idx),
    .regs     (regs)
  );

  always_comb begin
    status = '0;
    status[STAT_START] = started;
    status[STAT_PEND]  = req_tgl ^ ack_tgl;
  end

  assign rd_val   = host_sel ? regs[idx] : status;
  assign rd_drive = host_rnw && !host_strobe;
  assign host_bus = rd_drive ? rd_val : 8'bz;

  assign chain_rst_out = rst || !started;
  assign cfg_regs      = regs;
endmodule

// File: tb/tb_hrb_host_port.sv
module tb_hrb_host_port;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_sel = 1'b0;
  logic host_rnw = 1'b0;
  logic host_strobe = 1'b1;
  logic [7:0] drv = '0;
  logic drv_en = 1'b0;
  wire  [7:0] host_bus;
  logic chain_rst_out;
  logic [NREG*8-1:0] cfg_regs;

  assign host_bus = drv_en ? drv : 8'bz;

  hrb_host_port #(.NREG(NREG)) dut (
    .clk(clk), .rst(rst), .host_bus(host_bus), .host_sel(host_sel),
    .host_rnw(host_rnw), .host_strobe(host_strobe),
    .chain_rst_out(chain_rst_out), .cfg_regs(cfg_regs)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_regs [NREG];
  int exp_idx = 0;
  bit exp_started = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic host_write(input logic sel, input logic [7:0] val, input bit wait_ack);
    @(negedge clk);
    drv = val; drv_en = 1'b1; host_rnw = 1'b0; host_sel = sel;
    #1 host_strobe = 1'b0;
    #2 host_strobe = 1'b1;
    #1 drv_en = 1'b0;
    if (wait_ack) settle();
  endtask

  task automatic host_read(input logic sel, output logic [7:0] val);
    drv_en = 1'b0; host_rnw = 1'b1; host_sel = sel;
    #1 host_strobe = 1'b0;
    #2 val = host_bus;
    #1 host_strobe = 1'b1;
    #1 host_rnw = 1'b0;
    if (sel) settle();
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f = '0;
    for (int k = 0; k < NREG; k++) f[k*8 +: 8] = exp_regs[k];
    return f;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R1 chain out after reset", 64'(chain_rst_out), 64'd1);
    host_read(1'b0, rv);
    chk("R1 R3 status after reset", 64'(rv), 64'h00);
    chk("R1 R11 registers after reset", 64'(cfg_regs), 64'h0);

    // R5 pending window
    host_write(1'b0, 8'h03, 0);
    host_read(1'b0, rv);
    chk("R5 pending set", 64'(rv), 64'h02);
    settle();
    host_read(1'b0, rv);
    chk("R5 pending cleared", 64'(rv), 64'h00);
    exp_idx = 3;
    host_read(1'b1, rv);
    chk("R9 R7 read at loaded index", 64'(rv), 64'(exp_regs[exp_idx]));
    exp_idx = (exp_idx + 1) % NREG;

    // R7 R8 R9 R11 sweep over every start index
    for (int s = 0; s < NREG; s++) begin
      logic [7:0] op = 8'(s + NREG * (1 + s % 3));
      host_write(1'b0, op, 1);
      exp_idx = op % NREG;
      chk("R7 index load leaves registers", 64'(cfg_regs), model_flat());
      for (int k = 0; k < NREG; k++) begin
        logic [7:0] d = 8'((s * 29 + k * 13 + 7) ^ (s << 4));
        host_write(1'b1, d, 1);
        exp_regs[exp_idx] = d;
        exp_idx = (exp_idx + 1) % NREG;
      end
      chk("R8 R11 register file after writes", 64'(cfg_regs), model_flat());
      host_write(1'b0, op, 1);
      exp_idx = op % NREG;
      for (int k = 0; k <= NREG; k++) begin
        host_read(1'b1, rv);
        chk("R9 auto-increment read", 64'(rv), 64'(exp_regs[exp_idx]));
        exp_idx = (exp_idx + 1) % NREG;
      end
      chk("R6 chain held before start", 64'(chain_rst_out), 64'd1);
    end

    // R6 R7 start command
    host_write(1'b0, 8'h02, 1);
    exp_idx = 2;
    host_write(1'b0, 8'h01, 1);
    exp_started = 1;
    chk("R6 chain released by start", 64'(chain_rst_out), 64'd0);
    host_read(1'b0, rv);
    chk("R3 R6 status started", 64'(rv), 64'h01);
    host_read(1'b0, rv);
    host_read(1'b1, rv);
    chk("R7 R3 start and status keep index", 64'(rv), 64'(exp_regs[2]));
    host_write(1'b0, 8'h06, 1);
    chk("R6 started sticky after other command", 64'(chain_rst_out), 64'd0);
    host_write(1'b1, 8'h5A, 1);
    exp_regs[6] = 8'h5A;
    chk("R2 R8 host data reaches register", 64'(cfg_regs), model_flat());

    // R10 asynchronous reset
    @(negedge clk);
    #2 rst = 1'b1;
    #1 chk("R10 chain rises without clock", 64'(chain_rst_out), 64'd1);
    chk("R10 registers cleared", 64'(cfg_regs), 64'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    host_read(1'b0, rv);
    chk("R10 started cleared", 64'(rv), 64'h00);
    for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
    host_write(1'b1, 8'hC3, 1);
    exp_regs[0] = 8'hC3;
    chk("R10 index cleared to zero", 64'(cfg_regs), model_flat());

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule